// File: doc/BRIEF.md
# Byte-Lane Data Memory with Mapped I/O

This block is the data-side memory of a small 32-bit RISC-V style core. It takes a byte address, store data, a read strobe, a write strobe and the load/store size code from the instruction's funct3 field. RAM storage is split into four 8-bit banks, one per byte lane. Each bank has its own write enable, so byte and half-word stores touch only the lanes they cover, and each bank maps onto an FPGA block RAM.

An address decoder splits the space into regions:
- a RAM window starting at 0x80000000;
- a few read-only identification words starting at 0x00100000;
- a read-only switch input port;
- a read/write LED register.

Loads have one cycle of latency. The returned value is taken from the selected lane(s) and then sign- or zero-extended. Aligned accesses are expected: the offset bits that a given size does not use are ignored rather than trapped.

Top module: `lane_data_mem`

## Requirements
- R1: After synchronous reset, `rdata` reads 0 and `led_out` reads 0.
- R2: A word store (size 010) to RAM at byte address 0x80000000 + 4·i is returned unchanged by a later word load from the same address. The word index is taken from address bits above bit 1 inside the RAM window.
- R3: A byte store (size 000 or 100) writes only lane `addr[1:0]` with `wdata[7:0]`. Lane 0 is bits 7:0 and lane 3 is bits 31:24 of the word. The other three lanes keep their contents.
- R4: A half-word store (size 001 or 101) writes `wdata[15:0]` into bits 15:0 when `addr[1]` is 0, or into bits 31:16 when `addr[1]` is 1. `addr[0]` is ignored, and the other half keeps its contents.
- R5: Loads select lanes in the same way as R3 and R4 and extend the result as follows:
  - 000: signed byte.
  - 100: unsigned byte.
  - 001: signed half.
  - 101: unsigned half.
  - 010: the full word.
- R6: Load data appears on `rdata` after the clock edge that samples `rd_en` high. It holds until the next edge that samples `rd_en` high, even while stores proceed.
- R7: When `rd_en` and `wr_en` are both high for the same address in one cycle, the load returns the previous contents. The stored value is seen by later loads.
- R8: Word loads from 0x00100000, 0x00100004 and 0x00100008 return the identification words 0, 1 and 2. Stores to them have no effect.
- R9: A load from 0x00100010 returns `sw_in` zero-extended, as sampled at the read edge. Stores there have no effect.
- R10: Stores to 0x00100014 update `led_out` through the same lane enables as RAM. Loads there return the current LED value zero-extended; a load issued together with a store returns the value from before the store.
- R11: Loads from unmapped addresses, including the first address past the RAM window, return 0. Stores to them change neither RAM nor `led_out`.
- R12: For size codes 011, 110 and 111, stores write nothing and loads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data, low-aligned |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| size | input | 3 | funct3 size/sign code |
| sw_in | input | SW_W | Switch input port |
| rdata | output | 32 | Extended load data |
| led_out | output | LED_W | LED register |

## Verification
A load and a store can fall in the same cycle. The bench provokes this by raising both strobes for one RAM word, and again for the LED register. It judges the result by the read-first rule: `rdata` must hold the old contents in that cycle, and a follow-up load must return the new value. Sweeps over a 64-word RAM check every lane and size code against a byte-level model kept in the bench.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RAM,
    RG_ID,
    RG_SW,
    RG_LED
  } region_t;

  typedef enum logic [1:0] {
    SZ_BAD,
    SZ_BYTE,
    SZ_HALF,
    SZ_WORD
  } width_t;

  typedef struct packed {
    width_t w;
    logic   sext;
  } acc_t;

  function automatic acc_t decode_size(input logic [2:0] f);
    acc_t a;
    a.w    = SZ_BAD;
    a.sext = 1'b0;
    case (f)
      3'b000: begin a.w = SZ_BYTE; a.sext = 1'b1; end
      3'b001: begin a.w = SZ_HALF; a.sext = 1'b1; end
      3'b010: a.w = SZ_WORD;
      3'b100: a.w = SZ_BYTE;
      3'b101: a.w = SZ_HALF;
      default: a.w = SZ_BAD;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/lmem_decode.sv
module lmem_decode
  import lmem_pkg::*;
#(
  parameter int          DEPTH_WORDS = 1024,
  parameter logic [31:0] RAM_BASE    = 32'h8000_0000,
  parameter logic [31:0] MMIO_BASE   = 32'h0010_0000,
  parameter int          ID_COUNT    = 3,
  parameter int          IDX_W       = $clog2(DEPTH_WORDS),
  parameter int          ID_SEL_W    = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1
) (
  input  logic [31:0]         addr,
  output region_t             region,
  output logic [IDX_W-1:0]    word_idx,
  output logic [ID_SEL_W-1:0] id_sel
);

  localparam logic [29:0] MW      = MMIO_BASE[31:2];
  localparam logic [29:0] SW_OFS  = 30'd4;
  localparam logic [29:0] LED_OFS = 30'd5;

  assign word_idx = addr[IDX_W+1:2];

  always_comb begin
    region = RG_NONE;
    id_sel = '0;
    if (addr[31:IDX_W+2] == RAM_BASE[31:IDX_W+2]) begin
      region = RG_RAM;
    end else if (addr[31:2] == MW + SW_OFS) begin
      region = RG_SW;
    end else if (addr[31:2] == MW + LED_OFS) begin
      region = RG_LED;
    end else begin
      for (int k = 0; k < ID_COUNT; k++) begin
        if (addr[31:2] == MW + 30'(k)) begin
          region = RG_ID;
          id_sel = ID_SEL_W'(k);
        end
      end
    end
  end

endmodule

// File: rtl/lmem_lanes.sv
module lmem_lanes
  import lmem_pkg::*;
(
  input  width_t      w,
  input  logic [1:0]  ofs,
  input  logic [31:0] wdata,
  output logic [3:0]  lane_en,
  output logic [31:0] lane_data
);

  always_comb begin
    lane_en   = 4'b0000;
    lane_data = wdata;
    case (w)
      SZ_BYTE: begin
        lane_en   = 4'b0001 << ofs;
        lane_data = {4{wdata[7:0]}};
      end
      SZ_HALF: begin
        lane_en   = ofs[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{wdata[15:0]}};
      end
      SZ_WORD: lane_en = 4'b1111;
      default: lane_en = 4'b0000;
    endcase
  end

endmodule

// File: rtl/lmem_extract.sv
module lmem_extract
  import lmem_pkg::*;
(
  input  acc_t        acc,
  input  logic [1:0]  ofs,
  input  logic [31:0] raw,
  output logic [31:0] value
);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = raw[{ofs, 3'b000} +: 8];
    sel_h = raw[{ofs[1], 4'b0000} +: 16];
    case (acc.w)
      SZ_BYTE: value = {{24{acc.sext & sel_b[7]}}, sel_b};
      SZ_HALF: value = {{16{acc.sext & sel_h[15]}}, sel_h};
      SZ_WORD: value = raw;
      default: value = 32'h0;
    endcase
  end

endmodule

// File: rtl/lmem_bank.sv
module lmem_bank #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);

  logic [7:0] cells [DEPTH];

  // read-first: the registered read sees the cell before this edge's write
  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wd;
    if (re) rd <= cells[idx];
  end

endmodule

// File: rtl/lane_data_mem.sv
module lane_data_mem
  import lmem_pkg::*;
#(
  parameter int          DEPTH_WORDS = 1024,
  parameter logic [31:0] RAM_BASE    = 32'h8000_0000,
  parameter logic [31:0] MMIO_BASE   = 32'h0010_0000,
  parameter int          ID_COUNT    = 3,
  parameter logic [ID_COUNT*32-1:0] ID_WORDS =
    {32'h1D00_0C03, 32'h1D00_0B02, 32'h1D00_0A01},
  parameter int          SW_W        = 16,
  parameter int          LED_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       addr,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [2:0]        size,
  input  logic [SW_W-1:0]   sw_in,
  output logic [31:0]       rdata,
  output logic [LED_W-1:0]  led_out
);

  localparam int IDX_W    = $clog2(DEPTH_WORDS);
  localparam int ID_SEL_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;
  localparam int LANES    = 4;

  region_t             region;
  logic [IDX_W-1:0]    word_idx;
  logic [ID_SEL_W-1:0] id_sel;
  acc_t                acc;
  logic [3:0]          lane_en;
  logic [31:0]         lane_data;
  logic [31:0]         bank_word;
  logic                ram_rd;
  logic                ram_wr;

  acc_t                rd_acc_q;
  logic [1:0]          rd_ofs_q;
  region_t             rd_reg_q;
  logic [31:0]         mmio_q;
  logic [LED_W-1:0]    led_q;
  logic [31:0]         raw_word;
  logic [31:0]         led_merge;

  assign acc    = decode_size(size);
  assign ram_rd = rd_en && (region == RG_RAM);
  assign ram_wr = wr_en && (region == RG_RAM);

  lmem_decode #(
    .DEPTH_WORDS(DEPTH_WORDS),
    .RAM_BASE   (RAM_BASE),
    .MMIO_BASE  (MMIO_BASE),
    .ID_COUNT   (ID_COUNT),
    .IDX_W      (IDX_W),
    .ID_SEL_W   (ID_SEL_W)
  ) u_dec (
    .addr    (addr),
    .region  (region),
    .word_idx(word_idx),
    .id_sel  (id_sel)
  );

  lmem_lanes u_lanes (
    .w        (acc.w),
    .ofs      (addr[1:0]),
    .wdata    (wdata),
    .lane_en  (lane_en),
    .lane_data(lane_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    lmem_bank #(
      .DEPTH(DEPTH_WORDS),
      .AW   (IDX_W)
    ) u_bank (
      .clk(clk),
      .we (ram_wr && lane_en[g]),
      .re (ram_rd),
      .idx(word_idx),
      .wd (lane_data[8*g +: 8]),
      .rd (bank_word[8*g +: 8])
    );
  end

  // LED register merges the enabled lanes over its current value
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      led_merge[8*i +: 8] = lane_en[i] ? lane_data[8*i +: 8]
                                       : 8'(32'(led_q) >> (8*i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q <= '0;
    end else if (wr_en && region == RG_LED) begin
      led_q <= led_merge[LED_W-1:0];
    end
  end

  // read context: captured on the strobe so rdata holds between reads
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_acc_q <= '{w: SZ_BAD, sext: 1'b0};
      rd_ofs_q <= 2'b00;
      rd_reg_q <= RG_NONE;
      mmio_q   <= 32'h0;
    end else if (rd_en) begin
      rd_acc_q <= acc;
      rd_ofs_q <= addr[1:0];
      rd_reg_q <= region;
      case (region)
        RG_ID:   mmio_q <= ID_WORDS[{id_sel, 5'd0} +: 32];
        RG_SW:   mmio_q <= 32'(sw_in);
        RG_LED:  mmio_q <= 32'(led_q);
        default: mmio_q <= 32'h0;
      endcase
    end
  end

  assign raw_word = (rd_reg_q == RG_RAM) ? bank_word : mmio_q;

  lmem_extract u_ext (
    .acc  (rd_acc_q),
    .ofs  (rd_ofs_q),
    .raw  (raw_word),
    .value(rdata)
  );

  assign led_out = led_q;

  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc.w == SZ_BYTE) |-> ($countones(lane_en) == 1));

  p_sext_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && size == 3'b000) |=> (rdata[31:8] == {24{rdata[7]}}));

  p_hold_rdata_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_led_guard_r10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && region == RG_LED) |=> $stable(led_out));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == RG_NONE) |=> (rdata == 32'h0));

  p_bad_size_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc.w == SZ_BAD) |=> (rdata == 32'h0));

  p_bad_size_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc.w == SZ_BAD) |-> (lane_en == 4'b0000));

endmodule

// File: tb/lane_data_mem_test.sv
module lane_data_mem_test;

  localparam int          DEPTH = 64;
  localparam logic [31:0] RB    = 32'h8000_0000;
  localparam logic [31:0] MB    = 32'h0010_0000;
  localparam logic [95:0] IDS   = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr = '0, wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  size = 3'b010;
  logic [15:0] sw_in = '0;
  logic [31:0] rdata;
  logic [15:0] led_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] model [0:255];

  always #2 clk = ~clk;

  lane_data_mem #(
    .DEPTH_WORDS(DEPTH), .RAM_BASE(RB), .MMIO_BASE(MB),
    .ID_COUNT(3), .ID_WORDS(IDS), .SW_W(16), .LED_W(16)
  ) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .size(size), .sw_in(sw_in), .rdata(rdata),
    .led_out(led_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(input logic [31:0] a);
    logic [7:0] b = {a[7:2], 2'b00};
    return {model[b+3], model[b+2], model[b+1], model[b]};
  endfunction

  function automatic logic [31:0] mload(input logic [31:0] a, input logic [2:0] f);
    logic [31:0] w = mword(a);
    logic [7:0]  by = 8'(w >> (8 * a[1:0]));
    logic [15:0] hf = a[1] ? w[31:16] : w[15:0];
    case (f)
      3'b000: return {{24{by[7]}}, by};
      3'b100: return {24'h0, by};
      3'b001: return {{16{hf[15]}}, hf};
      3'b101: return {16'h0, hf};
      3'b010: return w;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [31:0] d, input logic [2:0] f);
    logic [7:0] b;
    if (a[31:8] != RB[31:8]) return;
    case (f)
      3'b000, 3'b100: model[a[7:0]] = d[7:0];
      3'b001, 3'b101: begin
        b = {a[7:2], a[1], 1'b0};
        model[b] = d[7:0]; model[b+1] = d[15:8];
      end
      3'b010: begin
        b = {a[7:2], 2'b00};
        for (int i = 0; i < 4; i++) model[b+i] = 8'(d >> (8*i));
      end
      default: ;
    endcase
  endtask

  task automatic st(input logic [31:0] a, input logic [31:0] d, input logic [2:0] f);
    @(negedge clk);
    addr = a; wdata = d; size = f; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    model_store(a, d, f);
  endtask

  task automatic ld(input logic [31:0] a, input logic [2:0] f);
    @(negedge clk);
    addr = a; size = f; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 led", 32'(led_out), 32'h0);

    // R2: fill and read every word
    for (int i = 0; i < DEPTH; i++)
      st(RB + 32'(4*i), 32'h9E37_79B9 * 32'(i+1) ^ 32'(i << 3), 3'b010);
    for (int i = 0; i < DEPTH; i++) begin
      ld(RB + 32'(4*i), 3'b010);
      chk("R2 word", rdata, mword(RB + 32'(4*i)));
    end

    // R3: byte stores rotate through lanes, upper data bits are junk
    for (int i = 0; i < DEPTH; i++)
      st(RB + 32'(4*i + (i % 4)), 32'hAB5A_C300 | 32'((i*7 + 8'h80) & 8'hFF),
         (i % 2) ? 3'b100 : 3'b000);
    for (int i = 0; i < DEPTH; i++) begin
      ld(RB + 32'(4*i), 3'b010);
      chk("R3 byte lane", rdata, mword(RB + 32'(4*i)));
    end

    // R4: half stores, bit 0 of the address set on odd offsets
    for (int i = 0; i < 32; i++)
      st(RB + 32'(4*i + (i % 4)), 32'h7F00_0000 | 32'(16'h8001 + 16'(i*291)),
         (i % 2) ? 3'b101 : 3'b001);
    for (int i = 0; i < 32; i++) begin
      ld(RB + 32'(4*i), 3'b010);
      chk("R4 half lane", rdata, mword(RB + 32'(4*i)));
    end

    // R5: every lane and extension
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 4; o++) begin
        ld(RB + 32'(4*i + o), 3'b000);
        chk("R5 lb", rdata, mload(RB + 32'(4*i + o), 3'b000));
        ld(RB + 32'(4*i + o), 3'b100);
        chk("R5 lbu", rdata, mload(RB + 32'(4*i + o), 3'b100));
      end
      for (int o = 0; o < 4; o += 2) begin
        ld(RB + 32'(4*i + o), 3'b001);
        chk("R5 lh", rdata, mload(RB + 32'(4*i + o), 3'b001));
        ld(RB + 32'(4*i + o), 3'b101);
        chk("R5 lhu", rdata, mload(RB + 32'(4*i + o), 3'b101));
      end
    end

    // R6: hold across idle cycles and a store
    ld(RB + 32'd20, 3'b010);
    old = mword(RB + 32'd20);
    @(negedge clk); addr = RB + 32'd40;
    @(negedge clk);
    chk("R6 hold idle", rdata, old);
    st(RB + 32'd20, 32'h0BAD_F00D, 3'b010);
    chk("R6 hold store", rdata, old);

    // R7: read and write together
    old = mword(RB + 32'd28);
    @(negedge clk);
    addr = RB + 32'd28; wdata = 32'h1357_9BDF; size = 3'b010;
    rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    model_store(RB + 32'd28, 32'h1357_9BDF, 3'b010);
    chk("R7 old value", rdata, old);
    ld(RB + 32'd28, 3'b010);
    chk("R7 new value", rdata, 32'h1357_9BDF);

    // R8: identification words
    for (int k = 0; k < 3; k++) begin
      ld(MB + 32'(4*k), 3'b010);
      chk("R8 id", rdata, IDS[32*k +: 32]);
    end
    st(MB, 32'hFFFF_FFFF, 3'b010);
    ld(MB, 3'b010);
    chk("R8 id write ignored", rdata, IDS[31:0]);

    // R9: switches
    sw_in = 16'hA5C3;
    ld(MB + 32'h10, 3'b010);
    chk("R9 sw", rdata, 32'h0000_A5C3);
    sw_in = 16'h8421;
    ld(MB + 32'h10, 3'b010);
    chk("R9 sw change", rdata, 32'h0000_8421);
    st(MB + 32'h10, 32'h0000_1111, 3'b010);
    chk("R9 sw write led", 32'(led_out), 32'h0);
    ld(MB + 32'h10, 3'b010);
    chk("R9 sw write ignored", rdata, 32'h0000_8421);

    // R10: LED register
    st(MB + 32'h14, 32'h1234_5678, 3'b010);
    chk("R10 led word", 32'(led_out), 32'h5678);
    ld(MB + 32'h14, 3'b010);
    chk("R10 led read", rdata, 32'h0000_5678);
    st(MB + 32'h15, 32'h0000_00EE, 3'b000);
    chk("R10 led byte", 32'(led_out), 32'hEE78);
    @(negedge clk);
    addr = MB + 32'h14; wdata = 32'h0000_0F0F; size = 3'b010;
    rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 led read-first", rdata, 32'h0000_EE78);
    chk("R10 led after", 32'(led_out), 32'h0F0F);

    // R11: unmapped space
    ld(RB + 32'h100, 3'b010);
    chk("R11 past ram", rdata, 32'h0);
    st(RB + 32'h100, 32'hFFFF_FFFF, 3'b010);
    ld(RB, 3'b010);
    chk("R11 no alias", rdata, mword(RB));
    chk("R11 led kept", 32'(led_out), 32'h0F0F);
    ld(32'h0, 3'b010);
    chk("R11 zero addr", rdata, 32'h0);
    ld(MB + 32'h18, 3'b010);
    chk("R11 after led", rdata, 32'h0);

    // R12: undefined size codes
    old = mword(RB + 32'd12);
    st(RB + 32'd12, 32'hDEAD_BEEF, 3'b011);
    ld(RB + 32'd12, 3'b010);
    chk("R12 store none", rdata, old);
    ld(RB + 32'd12, 3'b110);
    chk("R12 load zero", rdata, 32'h0);
    ld(RB + 32'd12, 3'b111);
    chk("R12 load zero 111", rdata, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule